// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Image Filter

The block filters a raster of RGB pixels, each made of three 4-bit channels, as the pixels stream past. Two row memories keep the two most recent image rows, and a 3x3 register window forms the neighbourhood of the pixel one row and one column behind the newest sample. Slide-switch inputs choose the kernel: pass-through, a 3x3 box blur, or a Laplacian edge detector. Each channel can be inverted after the kernel and enabled or blanked on its own. All of these settings may be combined.

The input is a valid-qualified pixel stream with a start-of-frame flag on the first pixel of each frame. Frames are always complete: IMG_H rows of IMG_W samples. The pipeline moves only on accepted samples. Each accepted sample, once the pipeline is full, releases exactly one filtered pixel, and that pixel trails its input by a fixed number of samples. The frame's edge pixels come out as zero.

Top module: `conv3_filter`

## Requirements
- R1: While reset (rstN low) is asserted, and on the first clock edge after it is released, outValid, outSof and outPix are all 0.
- R2: outValid pulses high for exactly one cycle after each accepted input cycle (inValid high), and only once at least IMG_W+4 samples have been accepted since reset. The pixel it carries is the input sample accepted IMG_W+3 samples earlier. Cycles with inValid low move nothing, and outPix holds its value through them.
- R3: With modeSel 0 or 3, a channel's value is the centre sample's value for that channel.
- R4: With modeSel 1, a channel's value is (S*7)>>6, clamped to 15. S is the sum of that channel over the 3x3 neighbourhood.
- R5: With modeSel 2, a channel's value is |8*centre - sum of the eight neighbours|, saturated to 15.
- R6: With invertEn high, each enabled channel outputs 15 minus its kernel result.
- R7: chanEn bit 2 enables outPix[11:8], bit 1 enables outPix[7:4] and bit 0 enables outPix[3:0]. A disabled channel outputs 0 whether or not inversion is on.
- R8: Pixels in the first or last row, or in the first or last column, of a frame are output as 0 under every setting.
- R9: outSof is high together with outValid for the pixel at row 0, column 0, and never at any other time. An input sample with inSof high is taken as row 0, column 0.
- R10: For a pixel, the neighbourhood is made of the samples at stream offsets 0, ±1, ±IMG_W and ±IMG_W±1. The modeSel, invertEn and chanEn values that apply to it are those present on the accepted cycle of the sample IMG_W+2 positions after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample present this cycle |
| inSof | input | 1 | Input sample is the first of a frame |
| inPix | input | 12 | Input pixel, red in [11:8], green in [7:4], blue in [3:0] |
| modeSel | input | 2 | Kernel: 0 or 3 pass, 1 blur, 2 Laplacian |
| invertEn | input | 1 | Invert the kernel result |
| chanEn | input | 3 | Per-channel enable |
| outValid | output | 1 | Filtered pixel present this cycle |
| outSof | output | 1 | Filtered pixel is row 0, column 0 |
| outPix | output | 12 | Filtered pixel |

## Verification
The bench aims at the seams of the stream. It inserts gaps in inValid; a pipeline that advanced on idle cycles would repeat or lose pixels and shift the latency. It changes the switches at frame boundaries, so that the last interior pixels of a frame are filtered with the next frame's settings; sampling the settings at the wrong stage changes those pixels. It drives flat frames where the blur must give 14 and the inverted Laplacian 15, a lone bright dot that must saturate the edge detector, and a fully masked frame with inversion on that must stay 0. A mid-stream reset checks that the priming delay starts again from zero.

// File: rtl/conv3_pkg.sv
package conv3_pkg;

  typedef enum logic [1:0] {
    MODE_PASS     = 2'd0,
    MODE_BLUR     = 2'd1,
    MODE_EDGE     = 2'd2,
    MODE_PASS_ALT = 2'd3
  } filterMode_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic advance;  // a sample is accepted this cycle
    logic zeroOut;  // pixel now in the kernel stage is on the frame edge
  } convStrobes_t;

endpackage

// File: rtl/conv3_ctrl.sv
module conv3_ctrl
  import conv3_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  localparam int COLW = $clog2(IMG_W),
  localparam int ROWW = $clog2(IMG_H)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inSof,
  output convStrobes_t    strobes,
  output logic [COLW-1:0] lbAddr,
  output logic            outValid,
  output logic            outSof
);
  localparam int LAT    = IMG_W + 3;
  localparam int PRIMEW = $clog2(LAT + 1);

  logic [COLW-1:0]   nxtCol, curCol, cCol;
  logic [ROWW-1:0]   nxtRow, curRow, cRow;
  logic [PRIMEW-1:0] primeCnt;
  logic              winBorder, winSof, kernBorder, kernSof;
  logic              edgeNow, originNow, primed;

  // Position of the accepted sample, then of the window centre (W+1 behind).
  always_comb begin
    int rowTmp;
    curCol = inSof ? '0 : nxtCol;
    curRow = inSof ? '0 : nxtRow;
    cCol   = (curCol == '0) ? COLW'(IMG_W - 1) : curCol - 1'b1;
    rowTmp = int'(curRow) - ((curCol == '0) ? 2 : 1);
    if (rowTmp < 0) rowTmp = rowTmp + IMG_H;
    cRow      = ROWW'(rowTmp);
    edgeNow   = (cRow == '0) || (cRow == ROWW'(IMG_H - 1)) ||
                (cCol == '0) || (cCol == COLW'(IMG_W - 1));
    originNow = (cRow == '0) && (cCol == '0);
    primed    = (primeCnt >= PRIMEW'(LAT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nxtCol     <= '0;
      nxtRow     <= '0;
      lbAddr     <= '0;
      primeCnt   <= '0;
      winBorder  <= 1'b0;
      winSof     <= 1'b0;
      kernBorder <= 1'b0;
      kernSof    <= 1'b0;
      outValid   <= 1'b0;
      outSof     <= 1'b0;
    end else begin
      outValid <= inValid && primed;
      outSof   <= inValid && primed && kernSof;
      if (inValid) begin
        if (curCol == COLW'(IMG_W - 1)) begin
          nxtCol <= '0;
          nxtRow <= (curRow == ROWW'(IMG_H - 1)) ? '0 : curRow + 1'b1;
        end else begin
          nxtCol <= curCol + 1'b1;
          nxtRow <= curRow;
        end
        lbAddr     <= (lbAddr == COLW'(IMG_W - 1)) ? '0 : lbAddr + 1'b1;
        if (!primed) primeCnt <= primeCnt + 1'b1;
        winBorder  <= edgeNow;
        winSof     <= originNow;
        kernBorder <= winBorder;
        kernSof    <= winSof;
      end
    end
  end

  assign strobes.advance = inValid;
  assign strobes.zeroOut = kernBorder;

endmodule

// File: rtl/conv3_datapath.sv
module conv3_datapath
  import conv3_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int CH_W  = 4,
  parameter int N_CH  = 3,
  localparam int COLW  = $clog2(IMG_W),
  localparam int PIX_W = CH_W * N_CH
) (
  input  logic             clk,
  input  logic             rstN,
  input  convStrobes_t     strobes,
  input  logic [COLW-1:0]  lbAddr,
  input  logic [PIX_W-1:0] inPix,
  input  logic [1:0]       modeSel,
  input  logic             invertEn,
  input  logic [N_CH-1:0]  chanEn,
  output logic [PIX_W-1:0] outPix
);
  localparam int MAXV = (1 << CH_W) - 1;

  logic [PIX_W-1:0] rowMem1 [IMG_W];
  logic [PIX_W-1:0] rowMem2 [IMG_W];
  logic [PIX_W-1:0] tap1, tap2;
  logic [PIX_W-1:0] win [3][3];
  logic [PIX_W-1:0] kernNext, kernReg;

  assign tap1 = rowMem1[lbAddr];
  assign tap2 = rowMem2[lbAddr];

  // Row memories: one row and two rows of delay in sample order.
  always_ff @(posedge clk) begin
    if (strobes.advance) begin
      rowMem1[lbAddr] <= inPix;
      rowMem2[lbAddr] <= tap1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++) win[r][c] <= '0;
    end else if (strobes.advance) begin
      for (int r = 0; r < 3; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
      end
      win[0][2] <= tap2;
      win[1][2] <= tap1;
      win[2][2] <= inPix;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    logic [CH_W-1:0] chanOut;
    always_comb begin
      int sum, mid, val;
      sum = 0;
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          sum = sum + int'(win[r][c][ch*CH_W +: CH_W]);
      mid = int'(win[1][1][ch*CH_W +: CH_W]);
      case (filterMode_t'(modeSel))
        MODE_BLUR: val = (sum * 7) >>> 6;
        MODE_EDGE: begin
          val = 9 * mid - sum;
          if (val < 0) val = -val;
        end
        default:   val = mid;
      endcase
      if (val > MAXV) val = MAXV;
      if (invertEn) val = MAXV - val;
      if (!chanEn[ch]) val = 0;
      chanOut = CH_W'(val);
    end
    assign kernNext[ch*CH_W +: CH_W] = chanOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kernReg <= '0;
      outPix  <= '0;
    end else if (strobes.advance) begin
      kernReg <= kernNext;
      outPix  <= strobes.zeroOut ? '0 : kernReg;
    end
  end

endmodule

// File: rtl/conv3_filter.sv
module conv3_filter
  import conv3_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int CH_W  = 4,
  parameter int N_CH  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inSof,
  input  logic [CH_W*N_CH-1:0] inPix,
  input  logic [1:0]           modeSel,
  input  logic                 invertEn,
  input  logic [N_CH-1:0]      chanEn,
  output logic                 outValid,
  output logic                 outSof,
  output logic [CH_W*N_CH-1:0] outPix
);
  localparam int COLW = $clog2(IMG_W);

  convStrobes_t    strobes;
  logic [COLW-1:0] lbAddr;

  conv3_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof),
    .strobes(strobes), .lbAddr(lbAddr), .outValid(outValid), .outSof(outSof)
  );

  conv3_datapath #(.IMG_W(IMG_W), .CH_W(CH_W), .N_CH(N_CH)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lbAddr(lbAddr),
    .inPix(inPix), .modeSel(modeSel), .invertEn(invertEn), .chanEn(chanEn),
    .outPix(outPix)
  );

endmodule

// File: rtl/conv3_filter_chk.sv
module conv3_filter_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic             outSof,
  input logic [PIX_W-1:0] outPix
);
  AST_OUT_QUIET_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && !outSof && outPix == '0)); // R1

  AST_VALID_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> ($stable(outPix) && !outValid)); // R2

  AST_SOF_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid); // R9

endmodule

bind conv3_filter conv3_filter_chk #(.PIX_W(CH_W*N_CH)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid),
  .outValid(outValid), .outSof(outSof), .outPix(outPix)
);

// File: tb/test_conv3_filter.sv
module test_conv3_filter;
  localparam int W = 12;
  localparam int H = 7;
  localparam int LAT = W + 3;
  localparam int MAXS = 4096;
  localparam int NCASE = 10;
  // {pattern[1:0], mode[1:0], invert, chanEn[2:0]}
  localparam logic [7:0] CASES [NCASE] = '{
    {2'd0, 2'd0, 1'b0, 3'b111},
    {2'd0, 2'd1, 1'b0, 3'b111},
    {2'd1, 2'd1, 1'b0, 3'b111},
    {2'd0, 2'd2, 1'b0, 3'b111},
    {2'd2, 2'd2, 1'b0, 3'b111},
    {2'd3, 2'd2, 1'b1, 3'b101},
    {2'd1, 2'd2, 1'b1, 3'b111},
    {2'd3, 2'd0, 1'b1, 3'b010},
    {2'd0, 2'd3, 1'b0, 3'b111},
    {2'd3, 2'd1, 1'b1, 3'b000}
  };

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, inSof = 1'b0, invertEn = 1'b0;
  logic [11:0] inPix = '0;
  logic [1:0] modeSel = '0;
  logic [2:0] chanEn = 3'b111;
  logic outValid, outSof;
  logic [11:0] outPix;

  int checkCnt = 0, failCnt = 0, sentCnt = 0, outIdx = 0, bRow = 0, bCol = 0;
  logic [11:0] samp [MAXS];
  logic [5:0]  setv [MAXS];
  int posR [MAXS];
  int posC [MAXS];

  always #2.5 clk = ~clk;

  conv3_filter #(.IMG_W(W), .IMG_H(H)) i_conv3_filter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inPix(inPix),
    .modeSel(modeSel), .invertEn(invertEn), .chanEn(chanEn),
    .outValid(outValid), .outSof(outSof), .outPix(outPix)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int chan(input logic [11:0] p, input int ch);
    return int'((p >> (ch * 4)) & 12'hF);
  endfunction

  function automatic logic [11:0] expPix(input int m);
    logic [5:0] s;
    logic [11:0] res;
    int sum, mid, v;
    res = '0;
    if (posR[m] == 0 || posR[m] == H - 1 || posC[m] == 0 || posC[m] == W - 1)
      return res;                                     // R8
    s = setv[m + W + 2];                              // R10
    for (int ch = 0; ch < 3; ch++) begin
      sum = 0;
      for (int dr = -1; dr <= 1; dr++)
        for (int dc = -1; dc <= 1; dc++) sum += chan(samp[m + dr * W + dc], ch);
      mid = chan(samp[m], ch);
      if (s[5:4] == 2'd1) v = (sum * 7) / 64;         // R4
      else if (s[5:4] == 2'd2) begin                  // R5
        v = 9 * mid - sum;
        if (v < 0) v = -v;
      end else v = mid;                               // R3
      if (v > 15) v = 15;
      if (s[3]) v = 15 - v;                           // R6
      if (!s[ch]) v = 0;                              // R7
      res[ch*4 +: 4] = 4'(v);
    end
    return res;
  endfunction

  function automatic string pixTag(input int m);
    logic [5:0] s;
    s = setv[m + W + 2];
    if (posR[m] == 0 || posR[m] == H - 1 || posC[m] == 0 || posC[m] == W - 1) return "R8";
    if (s != setv[m]) return "R10";
    if (s[2:0] != 3'b111) return "R7";
    if (s[3]) return "R6";
    if (s[5:4] == 2'd1) return "R4";
    if (s[5:4] == 2'd2) return "R5";
    return "R3";
  endfunction

  function automatic logic [11:0] genPix(input int pat, input int r, input int c);
    logic [11:0] p;
    case (pat)
      0: p = 12'($urandom);
      1: p = 12'hFFF;
      2: p = (r == 3 && c == 5) ? 12'hFFF : 12'h000;
      default: for (int ch = 0; ch < 3; ch++) p[ch*4 +: 4] = 4'((r * 3 + c + ch * 5) % 16);
    endcase
    return p;
  endfunction

  task automatic sendFrame(input logic [7:0] cfg, input bit gaps);
    for (int i = 0; i < W * H; i++) begin
      @(negedge clk);
      while (gaps && ($urandom % 4 == 0)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      modeSel = cfg[4:3]; invertEn = cfg[2]; chanEn = cfg[1:0] == 2'b00 && cfg[2:0] == 3'b000 ? 3'b000 : cfg[2:0];
      invertEn = cfg[3];
      modeSel = cfg[5:4];
      chanEn = cfg[2:0];
      inSof = (i == 0);
      if (i == 0) begin bRow = 0; bCol = 0; end
      inPix = genPix(int'(cfg[7:6]), bRow, bCol);
      samp[sentCnt] = inPix;
      setv[sentCnt] = {cfg[5:4], cfg[3], cfg[2:0]};
      posR[sentCnt] = bRow;
      posC[sentCnt] = bCol;
      sentCnt++;
      inValid = 1'b1;
      if (bCol == W - 1) begin bCol = 0; bRow = (bRow == H - 1) ? 0 : bRow + 1; end
      else bCol++;
    end
    @(negedge clk);
    inValid = 1'b0;
    inSof = 1'b0;
  endtask

  // Monitor, one time unit after each rising edge.
  always begin
    @(posedge clk);
    #1;
    if (rstN) begin
      if (inValid || outValid)
        check(outValid == (inValid && (sentCnt - 1 >= LAT)), "R2",
              int'(outValid), int'(inValid && (sentCnt - 1 >= LAT)));
      if (outValid) begin
        check(sentCnt - 1 == outIdx + LAT, "R2", sentCnt - 1, outIdx + LAT);
        check(outPix == expPix(outIdx), pixTag(outIdx), int'(outPix), int'(expPix(outIdx)));
        check(outSof == (posR[outIdx] == 0 && posC[outIdx] == 0), "R9",
              int'(outSof), int'(posR[outIdx] == 0 && posC[outIdx] == 0));
        outIdx++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!outValid && !outSof && outPix == '0, "R1", int'(outPix), 0);
    rstN = 1'b1;
    for (int k = 0; k < NCASE; k++) sendFrame(CASES[k], k[0]);
    sendFrame({2'd3, 2'd0, 1'b0, 3'b111}, 1'b0);
    // Reset in mid-stream: outputs clear and priming restarts.
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!outValid && !outSof && outPix == '0, "R1", int'(outPix), 0);
    sentCnt = 0;
    outIdx = 0;
    @(negedge clk);
    rstN = 1'b1;
    sendFrame({2'd0, 2'd2, 1'b1, 3'b110}, 1'b1);
    sendFrame({2'd2, 2'd1, 1'b0, 3'b111}, 1'b0);
    check(outIdx == 2 * W * H - LAT, "R2", outIdx, 2 * W * H - LAT);
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule